// File: doc/BRIEF.md
# Interleave Trigger Sequencer for a Master/Slave Converter Pair

This block schedules the start pulses of two analog-to-digital converter back ends, a master and a slave, that convert the same input in turn. A regular trigger launches the master at once. The slave follows after a programmable number of converter clock cycles. The block then waits until both back ends report done. At that point it raises a joint end-of-conversion pulse and moves to the next step of the regular sequence. Each back end is modelled only as a start pulse and a done pulse.

The regular sequence can run to its end on one trigger. In discontinuous mode it is split into groups instead, and each group needs a fresh trigger. An injected trigger takes priority over regular work. If regular conversions are in flight, it aborts them on both converters together. When the injected conversion is done, the interrupted step starts again from the master without a new trigger. In an alternate injected mode, only the master's injected trigger is used, and each such trigger goes to the master and the slave by turns.

A regular trigger that arrives while the block is busy is dropped and marked in a sticky overrun flag.

Top module: `ilv_trig_seq`

## Requirements
- R1: Out of reset, every pulse output, `ovrFlag` and `stepIdx` read zero.
- R2: A regular trigger taken while idle gives `mstStart` one cycle later. `slvStart` follows `cfgSlvDelay` cycles after `mstStart`. A delay of zero puts both starts in the same cycle.
- R3: One cycle after the clock edge at which both done pulses of a step have been seen (in either order, or in the same cycle), `pairEoc` pulses and `stepIdx` advances.
- R4: With discontinuous mode off, a single trigger runs the whole sequence. Each following `mstStart` coincides with `pairEoc`. On the step whose index equals `cfgSeqLast`, `seqEos` pulses with `pairEoc`, `stepIdx` returns to 0 and the block goes idle.
- R5: With `cfgDiscEn` set, each trigger runs `cfgDiscNum`+1 steps and then idles with `stepIdx` held. The last group is cut short at the end of the sequence.
- R6: A regular trigger while busy starts nothing and sets `ovrFlag`. The flag stays set until `ovrClr`. When a trigger and `ovrClr` arrive together, the set wins.
- R7: An injected trigger during regular work pulses `regAbort` together with the injected start one cycle later. The aborted step gives no `pairEoc` and no pending slave start, and `stepIdx` is unchanged.
- R8: One cycle after `injDone`, the aborted step restarts with `mstStart`, and `slvStart` follows after the programmed delay.
- R9: An injected trigger while idle gives no `regAbort`. After `injDone` the block stays idle with no regular start.
- R10: A regular trigger and an injected trigger in the same idle cycle run the injected conversion first. The regular step then starts from the master after `injDone`, and `ovrFlag` is not set.
- R11: `altActive` is 1 only when `cfgDualMode` = 5'b01001, `cfgInjEdge` is not 2'b00, and both injected-discontinuous bits are 0.
- R12: While `altActive` is set, `injTrigSlv` is ignored. Successive `injTrigMst` pulses produce `injStartMst` first, then `injStartSlv`, in turn.
- R13: While `altActive` is clear, `injTrigMst` leads to `injStartMst` and `injTrigSlv` leads to `injStartSlv`, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low reset |
| cfgSeqLast | input | 4 | Index of the last regular step |
| cfgDiscEn | input | 1 | Discontinuous grouping enable |
| cfgDiscNum | input | 3 | Group size minus one |
| cfgSlvDelay | input | 4 | Master-to-slave start delay in cycles |
| cfgDualMode | input | 5 | Dual mode code |
| cfgInjEdge | input | 2 | Injected trigger edge setting, 00 = software |
| cfgInjDiscMst | input | 1 | Injected discontinuous, master |
| cfgInjDiscSlv | input | 1 | Injected discontinuous, slave |
| regTrig | input | 1 | Regular trigger pulse |
| injTrigMst | input | 1 | Injected trigger from master selection |
| injTrigSlv | input | 1 | Injected trigger from slave selection |
| mstDone | input | 1 | Master regular conversion done |
| slvDone | input | 1 | Slave regular conversion done |
| injDone | input | 1 | Injected conversion done |
| ovrClr | input | 1 | Clears the overrun flag |
| mstStart | output | 1 | Master regular start pulse |
| slvStart | output | 1 | Slave regular start pulse |
| regAbort | output | 1 | Abort of regular work on both converters |
| injStartMst | output | 1 | Master injected start pulse |
| injStartSlv | output | 1 | Slave injected start pulse |
| pairEoc | output | 1 | Both converters finished the step |
| seqEos | output | 1 | End of the regular sequence |
| stepIdx | output | 4 | Current regular step |
| ovrFlag | output | 1 | Sticky overrun flag |
| altActive | output | 1 | Alternate injected mode in force |

## Verification
Regular-trigger acceptance and injected preemption can fall in the same cycle. The bench raises `regTrig` and `injTrigMst` on one idle edge and expects only `injStartMst` in the next cycle. After `injDone` it expects `mstStart`, and it expects `ovrFlag` to stay clear. A second collision pairs a busy-time trigger with `ovrClr` in the same edge, where the flag must end up set. Every expected pulse is queued with its cycle number, and any pulse that was not queued counts as a failure.

// File: rtl/ilv_seq_pkg.sv
package ilv_seq_pkg;
  localparam logic [4:0] ALT_MODE_CODE = 5'b01001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_INJ  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic kickStep;  // launch the current step on the master
    logic advStep;   // current step finished on both converters
    logic endSeq;    // finished step was the last one
    logic endGrp;    // finished step closes a discontinuous group
    logic abort;     // drop regular work on both converters
    logic injGo;     // issue an injected start
    logic ovrSet;    // regular trigger dropped
  } seqStrobe_t;
endpackage

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
  import ilv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regTrig,
  input  logic       injEff,
  input  logic       injDone,
  input  logic       bothDone,
  input  logic       lastStep,
  input  logic       grpLast,
  input  logic       cfgDiscEn,
  output seqStrobe_t str,
  output logic       running
);
  seqState_t state, stateNxt;
  logic resumePend;

  always_comb begin
    str      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (injEff) begin
          str.injGo = 1'b1;
          stateNxt  = ST_INJ;
        end else if (regTrig) begin
          str.kickStep = 1'b1;
          stateNxt     = ST_RUN;
        end
      end
      ST_RUN: begin
        str.ovrSet = regTrig;
        if (injEff) begin
          str.abort = 1'b1;
          str.injGo = 1'b1;
          stateNxt  = ST_INJ;
        end else if (bothDone) begin
          str.advStep = 1'b1;
          if (lastStep) begin
            str.endSeq = 1'b1;
            stateNxt   = ST_IDLE;
          end else if (cfgDiscEn && grpLast) begin
            str.endGrp = 1'b1;
            stateNxt   = ST_IDLE;
          end else begin
            str.kickStep = 1'b1;
          end
        end
      end
      ST_INJ: begin
        str.ovrSet = regTrig;
        if (injDone) begin
          if (resumePend) begin
            str.kickStep = 1'b1;
            stateNxt     = ST_RUN;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      resumePend <= 1'b0;
    end else begin
      state <= stateNxt;
      if (str.injGo)
        resumePend <= (state == ST_RUN) || regTrig;
      else if (state == ST_INJ && injDone)
        resumePend <= 1'b0;
    end
  end

  assign running = (state == ST_RUN);

  // R2: a launched step always leaves the block in the regular running state
  p_kick_enters_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.kickStep |=> running);

  // R8: finishing an injected conversion that interrupted work resumes regular running
  p_resume_after_inj_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INJ && injDone && resumePend) |=> running);
endmodule

// File: rtl/ilv_seq_dp.sv
module ilv_seq_dp
  import ilv_seq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int DLY_W  = 4,
  parameter int GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        str,
  input  logic              running,
  input  logic [STEP_W-1:0] cfgSeqLast,
  input  logic              cfgDiscEn,
  input  logic [GRP_W-1:0]  cfgDiscNum,
  input  logic [DLY_W-1:0]  cfgSlvDelay,
  input  logic [4:0]        cfgDualMode,
  input  logic [1:0]        cfgInjEdge,
  input  logic              cfgInjDiscMst,
  input  logic              cfgInjDiscSlv,
  input  logic              injTrigMst,
  input  logic              injTrigSlv,
  input  logic              mstDone,
  input  logic              slvDone,
  input  logic              ovrClr,
  output logic              bothDone,
  output logic              lastStep,
  output logic              grpLast,
  output logic              injEff,
  output logic              altActive,
  output logic              mstStart,
  output logic              slvStart,
  output logic              regAbort,
  output logic              injStartMst,
  output logic              injStartSlv,
  output logic              pairEoc,
  output logic              seqEos,
  output logic [STEP_W-1:0] stepIdx,
  output logic              ovrFlag
);
  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  logic [GRP_W-1:0] grpCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic             dlyAct;
  logic             mstSeen, slvSeen;
  logic             altTgl;
  logic             seenClr;

  assign altActive = (cfgDualMode == ALT_MODE_CODE) && (cfgInjEdge != 2'b00)
                     && !cfgInjDiscMst && !cfgInjDiscSlv;
  assign injEff    = altActive ? injTrigMst : (injTrigMst | injTrigSlv);
  assign bothDone  = (mstSeen | mstDone) & (slvSeen | slvDone);
  assign lastStep  = (stepIdx == cfgSeqLast);
  assign grpLast   = (grpCnt == cfgDiscNum);
  assign seenClr   = str.kickStep | str.abort | str.advStep;

  // slave start delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyAct   <= 1'b0;
      dlyCnt   <= '0;
      mstStart <= 1'b0;
      slvStart <= 1'b0;
    end else begin
      mstStart <= str.kickStep;
      slvStart <= (str.kickStep && cfgSlvDelay == '0)
                  || (dlyAct && dlyCnt == DLY_ONE && !str.abort);
      if (str.abort) begin
        dlyAct <= 1'b0;
      end else if (str.kickStep) begin
        dlyAct <= (cfgSlvDelay != '0);
        dlyCnt <= cfgSlvDelay;
      end else if (dlyAct) begin
        dlyCnt <= dlyCnt - DLY_ONE;
        if (dlyCnt == DLY_ONE) dlyAct <= 1'b0;
      end
    end
  end

  // completion tracking and sequence position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mstSeen <= 1'b0;
      slvSeen <= 1'b0;
      stepIdx <= '0;
      grpCnt  <= '0;
      pairEoc <= 1'b0;
      seqEos  <= 1'b0;
    end else begin
      pairEoc <= str.advStep;
      seqEos  <= str.endSeq;
      if (seenClr) begin
        mstSeen <= 1'b0;
        slvSeen <= 1'b0;
      end else if (running) begin
        mstSeen <= mstSeen | mstDone;
        slvSeen <= slvSeen | slvDone;
      end
      if (str.advStep) begin
        stepIdx <= str.endSeq ? '0 : stepIdx + STEP_W'(1);
        grpCnt  <= (str.endSeq || str.endGrp || !cfgDiscEn) ? '0 : grpCnt + GRP_W'(1);
      end
    end
  end

  // injected steering, abort and overrun
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAbort    <= 1'b0;
      injStartMst <= 1'b0;
      injStartSlv <= 1'b0;
      altTgl      <= 1'b0;
      ovrFlag     <= 1'b0;
    end else begin
      regAbort    <= str.abort;
      injStartMst <= str.injGo && (altActive ? !altTgl : injTrigMst);
      injStartSlv <= str.injGo && (altActive ? altTgl : injTrigSlv);
      if (!altActive)     altTgl <= 1'b0;
      else if (str.injGo) altTgl <= !altTgl;
      if (str.ovrSet)     ovrFlag <= 1'b1;
      else if (ovrClr)    ovrFlag <= 1'b0;
    end
  end

  // R7: an aborted step never reports completion in the same cycle
  p_abort_no_eoc_r7: assert property (@(posedge clk) disable iff (!rstN)
    regAbort |-> !pairEoc);

  // R5: the group position stays inside the programmed group while grouping is on
  p_grp_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDiscEn && $stable(cfgDiscNum) && $stable(cfgDiscEn) && grpCnt <= cfgDiscNum)
      |=> grpCnt <= cfgDiscNum);
endmodule

// File: rtl/ilv_trig_seq.sv
module ilv_trig_seq
  import ilv_seq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int DLY_W  = 4,
  parameter int GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STEP_W-1:0] cfgSeqLast,
  input  logic              cfgDiscEn,
  input  logic [GRP_W-1:0]  cfgDiscNum,
  input  logic [DLY_W-1:0]  cfgSlvDelay,
  input  logic [4:0]        cfgDualMode,
  input  logic [1:0]        cfgInjEdge,
  input  logic              cfgInjDiscMst,
  input  logic              cfgInjDiscSlv,
  input  logic              regTrig,
  input  logic              injTrigMst,
  input  logic              injTrigSlv,
  input  logic              mstDone,
  input  logic              slvDone,
  input  logic              injDone,
  input  logic              ovrClr,
  output logic              mstStart,
  output logic              slvStart,
  output logic              regAbort,
  output logic              injStartMst,
  output logic              injStartSlv,
  output logic              pairEoc,
  output logic              seqEos,
  output logic [STEP_W-1:0] stepIdx,
  output logic              ovrFlag,
  output logic              altActive
);
  seqStrobe_t str;
  logic running, bothDone, lastStep, grpLast, injEff;

  ilv_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regTrig   (regTrig),
    .injEff    (injEff),
    .injDone   (injDone),
    .bothDone  (bothDone),
    .lastStep  (lastStep),
    .grpLast   (grpLast),
    .cfgDiscEn (cfgDiscEn),
    .str       (str),
    .running   (running)
  );

  ilv_seq_dp #(
    .STEP_W (STEP_W),
    .DLY_W  (DLY_W),
    .GRP_W  (GRP_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .str           (str),
    .running       (running),
    .cfgSeqLast    (cfgSeqLast),
    .cfgDiscEn     (cfgDiscEn),
    .cfgDiscNum    (cfgDiscNum),
    .cfgSlvDelay   (cfgSlvDelay),
    .cfgDualMode   (cfgDualMode),
    .cfgInjEdge    (cfgInjEdge),
    .cfgInjDiscMst (cfgInjDiscMst),
    .cfgInjDiscSlv (cfgInjDiscSlv),
    .injTrigMst    (injTrigMst),
    .injTrigSlv    (injTrigSlv),
    .mstDone       (mstDone),
    .slvDone       (slvDone),
    .ovrClr        (ovrClr),
    .bothDone      (bothDone),
    .lastStep      (lastStep),
    .grpLast       (grpLast),
    .injEff        (injEff),
    .altActive     (altActive),
    .mstStart      (mstStart),
    .slvStart      (slvStart),
    .regAbort      (regAbort),
    .injStartMst   (injStartMst),
    .injStartSlv   (injStartSlv),
    .pairEoc       (pairEoc),
    .seqEos        (seqEos),
    .stepIdx       (stepIdx),
    .ovrFlag       (ovrFlag)
  );

  // R4: end of sequence comes with the joint completion and a rewound index
  p_eos_with_eoc_r4: assert property (@(posedge clk) disable iff (!rstN)
    seqEos |-> (pairEoc && stepIdx == '0));

  // R6: the overrun flag holds until it is cleared
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !ovrClr) |=> ovrFlag);

  // R6: a clear with no trigger drops the flag
  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ovrClr && !regTrig) |=> !ovrFlag);

  // R7: every abort travels with an injected start
  p_abort_has_inj_r7: assert property (@(posedge clk) disable iff (!rstN)
    regAbort |-> (injStartMst || injStartSlv));

  // R12: alternate mode never starts both injected conversions at once
  p_alt_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    (altActive && $stable(altActive)) |-> !(injStartMst && injStartSlv));
endmodule

// File: tb/ilv_trig_seq_bench.sv
module ilv_trig_seq_bench;
  localparam int M_MST = 1, M_SLV = 2, M_ABT = 4, M_INJM = 8, M_INJS = 16,
                 M_EOC = 32, M_EOS = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cfgSeqLast = '0;
  logic cfgDiscEn = 1'b0;
  logic [2:0] cfgDiscNum = '0;
  logic [3:0] cfgSlvDelay = '0;
  logic [4:0] cfgDualMode = '0;
  logic [1:0] cfgInjEdge = 2'b01;
  logic cfgInjDiscMst = 1'b0, cfgInjDiscSlv = 1'b0;
  logic regTrig = 1'b0, injTrigMst = 1'b0, injTrigSlv = 1'b0;
  logic mstDone = 1'b0, slvDone = 1'b0, injDone = 1'b0, ovrClr = 1'b0;
  logic mstStart, slvStart, regAbort, injStartMst, injStartSlv, pairEoc, seqEos;
  logic [3:0] stepIdx;
  logic ovrFlag, altActive;

  ilv_trig_seq u_ilv_trig_seq (
    .clk(clk), .rstN(rstN), .cfgSeqLast(cfgSeqLast), .cfgDiscEn(cfgDiscEn),
    .cfgDiscNum(cfgDiscNum), .cfgSlvDelay(cfgSlvDelay), .cfgDualMode(cfgDualMode),
    .cfgInjEdge(cfgInjEdge), .cfgInjDiscMst(cfgInjDiscMst), .cfgInjDiscSlv(cfgInjDiscSlv),
    .regTrig(regTrig), .injTrigMst(injTrigMst), .injTrigSlv(injTrigSlv),
    .mstDone(mstDone), .slvDone(slvDone), .injDone(injDone), .ovrClr(ovrClr),
    .mstStart(mstStart), .slvStart(slvStart), .regAbort(regAbort),
    .injStartMst(injStartMst), .injStartSlv(injStartSlv), .pairEoc(pairEoc),
    .seqEos(seqEos), .stepIdx(stepIdx), .ovrFlag(ovrFlag), .altActive(altActive)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  typedef struct { int cyc; int mask; string req; } expItem_t;
  expItem_t expQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  function automatic void expectAt(input int c, input int m, input string r);
    expItem_t it;
    for (int i = 0; i < expQ.size(); i++) begin
      if (expQ[i].cyc == c) begin
        expQ[i].mask |= m;
        expQ[i].req = {expQ[i].req, " ", r};
        return;
      end else if (expQ[i].cyc > c) begin
        it.cyc = c; it.mask = m; it.req = r;
        expQ.insert(i, it);
        return;
      end
    end
    it.cyc = c; it.mask = m; it.req = r;
    expQ.push_back(it);
  endfunction

  // scoreboard monitor: compares the pulse outputs with the queued expectations
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int obs, expm;
      string r;
      obs = {25'd0, seqEos, pairEoc, injStartSlv, injStartMst, regAbort, slvStart, mstStart};
      expm = 0;
      r = "R2/R7 unexpected";
      while (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        chk(1'b0, expQ[0].req, "missed pulse set", 0, expQ[0].mask);
        void'(expQ.pop_front());
      end
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        expm = expQ[0].mask;
        r = expQ[0].req;
        void'(expQ.pop_front());
      end
      if ((obs | expm) != 0) chk(obs == expm, r, "pulse outputs", obs, expm);
    end
  end

  // driver: issue a regular trigger and queue the starts it should cause
  task automatic trigAndExpect(input int d, input bit pushSlv, output int s);
    int t;
    t = cyc;
    regTrig = 1'b1;
    s = t + 1;
    expectAt(s, M_MST | ((d == 0) ? M_SLV : 0), "R2");
    if (d > 0 && pushSlv) expectAt(s + d, M_SLV, "R2");
    @(negedge clk);
    regTrig = 1'b0;
  endtask

  // driver: answer a step started at cycle s and queue its completion
  task automatic finishStep(input int s, input int d, input int sep, input bit kick,
                            input bit eos, input int stepAfter, output int sNext);
    int x, m;
    while (cyc < s + d + 1) @(negedge clk);
    mstDone = 1'b1;
    if (sep == 0) slvDone = 1'b1;
    else begin
      @(negedge clk);
      mstDone = 1'b0;
      repeat (sep - 1) @(negedge clk);
      slvDone = 1'b1;
    end
    x = cyc;
    m = M_EOC | (eos ? M_EOS : 0);
    if (kick) m |= M_MST | ((d == 0) ? M_SLV : 0);
    expectAt(x + 1, m, eos ? "R3 R4" : (kick ? "R3 R4" : "R3 R5"));
    if (kick && d > 0) expectAt(x + 1 + d, M_SLV, "R2");
    @(negedge clk);
    mstDone = 1'b0;
    slvDone = 1'b0;
    chk(stepIdx == stepAfter[3:0], "R3", "stepIdx after step", stepIdx, stepAfter);
    sNext = x + 1;
  endtask

  task automatic injDoneAfter(input int waitN, input bit resume, input int d, output int s);
    repeat (waitN) @(negedge clk);
    injDone = 1'b1;
    s = cyc + 1;
    if (resume) begin
      expectAt(s, M_MST | ((d == 0) ? M_SLV : 0), "R8");
      if (d > 0) expectAt(s + d, M_SLV, "R8");
    end
    @(negedge clk);
    injDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog expired, actual 0 expected 1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int s, i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({mstStart, slvStart, regAbort, injStartMst, injStartSlv, pairEoc, seqEos} == 7'd0,
        "R1", "pulse outputs after reset", 0, 0);
    chk(stepIdx == 4'd0 && !ovrFlag, "R1", "stepIdx/ovrFlag after reset", stepIdx, 0);

    // continuous sequence of three steps, delay 4, overrun handling
    cfgSeqLast = 4'd2; cfgSlvDelay = 4'd4;
    trigAndExpect(4, 1'b1, s);
    regTrig = 1'b1;
    @(negedge clk);
    regTrig = 1'b0;
    chk(ovrFlag == 1'b1, "R6", "ovrFlag after busy trigger", ovrFlag, 1);
    finishStep(s, 4, 0, 1'b1, 1'b0, 1, s);
    ovrClr = 1'b1;
    @(negedge clk);
    ovrClr = 1'b0;
    chk(ovrFlag == 1'b0, "R6", "ovrFlag after clear", ovrFlag, 0);
    regTrig = 1'b1; ovrClr = 1'b1;
    @(negedge clk);
    regTrig = 1'b0; ovrClr = 1'b0;
    chk(ovrFlag == 1'b1, "R6", "set beats clear", ovrFlag, 1);
    finishStep(s, 4, 2, 1'b1, 1'b0, 2, s);
    finishStep(s, 4, 1, 1'b0, 1'b1, 0, s);
    repeat (3) @(negedge clk);
    chk(ovrFlag == 1'b1, "R6", "ovrFlag sticky while idle", ovrFlag, 1);
    ovrClr = 1'b1;
    @(negedge clk);
    ovrClr = 1'b0;

    // zero delay: both starts in one cycle, single step sequence
    cfgSeqLast = 4'd0; cfgSlvDelay = 4'd0;
    trigAndExpect(0, 1'b1, s);
    finishStep(s, 0, 0, 1'b0, 1'b1, 0, s);
    repeat (2) @(negedge clk);

    // R5 discontinuous groups of two over a three-step sequence
    cfgSeqLast = 4'd2; cfgSlvDelay = 4'd2; cfgDiscEn = 1'b1; cfgDiscNum = 3'd1;
    trigAndExpect(2, 1'b1, s);
    finishStep(s, 2, 0, 1'b1, 1'b0, 1, s);
    finishStep(s, 2, 1, 1'b0, 1'b0, 2, s);
    repeat (4) @(negedge clk);
    chk(stepIdx == 4'd2, "R5", "stepIdx held between groups", stepIdx, 2);
    trigAndExpect(2, 1'b1, s);
    finishStep(s, 2, 0, 1'b0, 1'b1, 0, s);
    repeat (2) @(negedge clk);
    cfgDiscEn = 1'b0;

    // R7 R8 abort after both converters started
    cfgSeqLast = 4'd1; cfgSlvDelay = 4'd3;
    trigAndExpect(3, 1'b1, s);
    while (cyc < s + 4) @(negedge clk);
    injTrigMst = 1'b1;
    expectAt(cyc + 1, M_ABT | M_INJM, "R7");
    @(negedge clk);
    injTrigMst = 1'b0;
    chk(stepIdx == 4'd0, "R7", "stepIdx kept on abort", stepIdx, 0);
    injDoneAfter(2, 1'b1, 3, s);
    finishStep(s, 3, 0, 1'b1, 1'b0, 1, s);
    finishStep(s, 3, 0, 1'b0, 1'b1, 0, s);

    // R7 abort before the slave start: pending slave start must vanish
    trigAndExpect(3, 1'b0, s);
    injTrigSlv = 1'b1;
    expectAt(cyc + 1, M_ABT | M_INJS, "R7 R13");
    @(negedge clk);
    injTrigSlv = 1'b0;
    injDoneAfter(4, 1'b1, 3, s);
    finishStep(s, 3, 1, 1'b1, 1'b0, 1, s);
    finishStep(s, 3, 0, 1'b0, 1'b1, 0, s);
    repeat (2) @(negedge clk);

    // R9 R13 injected trigger while idle
    injTrigSlv = 1'b1;
    expectAt(cyc + 1, M_INJS, "R9 R13");
    @(negedge clk);
    injTrigSlv = 1'b0;
    injDoneAfter(1, 1'b0, 0, s);
    repeat (4) @(negedge clk);
    chk(stepIdx == 4'd0 && !mstStart, "R9", "idle after idle injection", stepIdx, 0);

    // R10 coincident regular and injected triggers
    regTrig = 1'b1; injTrigMst = 1'b1;
    expectAt(cyc + 1, M_INJM, "R10");
    @(negedge clk);
    regTrig = 1'b0; injTrigMst = 1'b0;
    injDoneAfter(2, 1'b1, 3, s);
    chk(ovrFlag == 1'b0, "R10", "no overrun on coincident trigger", ovrFlag, 0);
    finishStep(s, 3, 0, 1'b1, 1'b0, 1, s);
    finishStep(s, 3, 0, 1'b0, 1'b1, 0, s);
    repeat (2) @(negedge clk);

    // R11 alternate mode qualification
    cfgDualMode = 5'b01001; cfgInjEdge = 2'b01;
    #1 chk(altActive == 1'b1, "R11", "altActive legal setup", altActive, 1);
    cfgInjEdge = 2'b00;
    #1 chk(altActive == 1'b0, "R11", "altActive with edge 00", altActive, 0);
    cfgInjEdge = 2'b10; cfgInjDiscSlv = 1'b1;
    #1 chk(altActive == 1'b0, "R11", "altActive with injected disc", altActive, 0);
    cfgInjDiscSlv = 1'b0; cfgDualMode = 5'b01000;
    #1 chk(altActive == 1'b0, "R11", "altActive wrong mode", altActive, 0);
    cfgDualMode = 5'b01001;
    #1 chk(altActive == 1'b1, "R11", "altActive restored", altActive, 1);
    @(negedge clk);

    // R12 alternate mode steering
    injTrigSlv = 1'b1;
    @(negedge clk);
    injTrigSlv = 1'b0;
    chk(!injStartSlv && !injStartMst, "R12", "slave trigger ignored", injStartSlv, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      injTrigMst = 1'b1;
      expectAt(cyc + 1, (k % 2 == 0) ? M_INJM : M_INJS, "R12");
      @(negedge clk);
      injTrigMst = 1'b0;
      i = (k % 2 == 0) ? 1 : 0;
      chk(injStartMst == i[0], "R12", "alternating target", injStartMst, i);
      injDoneAfter(1, 1'b0, 0, s);
      repeat (2) @(negedge clk);
    end
    cfgDualMode = 5'b00000;

    repeat (6) @(negedge clk);
    chk(expQ.size() == 0, "R2/R8", "pending expectations", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule